// File: doc/BRIEF.md
# Real-Time Clock Interrupt and Status Registers

This block holds the control and status side of a CMOS-style real-time clock. It sits next to a separate time-of-day counter. It is driven by a one-cycle strobe that marks each period of a 32.768 kHz time base. Software reaches it through a two-step port. It first writes an index byte, then reads or writes a data byte at that index. Four locations are decoded: a rate/divider register (index 0x0A), a control register (0x0B), a read-to-clear flag register (0x0C) and a constant power-status register (0x0D).

A periodic generator divides the time base by a power of two, chosen by a 4-bit rate code. An explicit state machine controls it, with three states:
- `PG_HOLD`: the divider is held in reset.
- `PG_IDLE`: the divider runs but the rate code is zero.
- `PG_COUNT`: the generator produces periodic events.

The transitions are:
- Hold-to-idle on release with code zero.
- Hold-to-count on release with a nonzero code.
- Idle-to-count when a code is set.
- Count-to-idle when the code is cleared.
- Any state to hold when the divider enters reset.

Periodic events, alarm-match pulses and update-ended pulses each set a sticky flag. The interrupt output is the OR of each set flag gated by its enable. The block also drives a square-wave output and a run qualifier for the time-of-day counter.

Top module: `rtc_event_ctrl`

## Requirements
- R1: Writing with `acc_sel`=0 loads the index. A data write (`acc_sel`=1) then updates the register at that index. Index 0x0B reads back all 8 written bits, and index 0x0A reads back bits 6-0. An undecoded index reads 0x00.
- R2: Bit 7 of a read at 0x0A returns `update_busy` as sampled at the read. Writes to that bit have no effect.
- R3: Rate code c in bits 3-0 of 0x0A, for c from 3 to 15, produces one periodic event every 2^(c-1) ticks. Code 1 behaves as code 8 (128 ticks), and code 2 as code 9 (256 ticks).
- R4: Rate code 0 produces no periodic events.
- R5: Divider code 110 or 111 in bits 6-4 of 0x0A holds the generator with no periodic events. On release, counting restarts from zero.
- R6: `tod_run` is high only when bits 6-4 of 0x0A are 010 and bit 7 of 0x0B is clear.
- R7: Each flag sets on its event whatever its enable. At 0x0C, bit 6 is the periodic flag, bit 5 the alarm flag and bit 4 the update flag. Bits 3-0 read 0.
- R8: Bit 7 of 0x0C and `irq` are high exactly when a set flag has its enable set. The enables are bit 6 (periodic), bit 5 (alarm) and bit 4 (update) of 0x0B.
- R9: A data read at 0x0C returns the flags, then clears all of them, so `irq` falls.
- R10: An event arriving in the same cycle as a read of 0x0C is not in the returned byte. Its flag remains set afterwards.
- R11: Writes at 0x0C and 0x0D are ignored. Index 0x0D always reads 0x80.
- R12: With bit 3 of 0x0B set and the generator counting, `sqw_out` is high for the second half of each period. Otherwise it is low.
- R13: After reset: 0x0A reads 0x20 (with `update_busy` low), 0x0B reads 0x00, 0x0C reads 0x00, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle strobe per 32.768 kHz period |
| acc_sel | input | 1 | 0 selects the index, 1 selects data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Data read strobe (with `acc_sel`=1) |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid the cycle after `rd_en` |
| update_busy | input | 1 | Time-of-day update in progress |
| alarm_match | input | 1 | Alarm compare pulse |
| update_done | input | 1 | Update-ended pulse |
| irq | output | 1 | Interrupt request, active high |
| sqw_out | output | 1 | Square-wave output |
| tod_run | output | 1 | Time-of-day counter may advance |

## Verification
The hardest situation to reach is an event that lands in the exact cycle the flag register is read and cleared. If it were mistimed, the event would either show up in the returned byte or be lost. The bench drives `update_done` on the same falling edge that raises the read strobe, so both reach the same rising edge. It then reads 0x0C twice: the first read must omit the flag and the second must show it. Periodic intervals are measured as the difference between two successive `irq` rises, which cancels the fixed pipeline offset.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;

    typedef enum logic [1:0] {
        PG_HOLD  = 2'd0,
        PG_IDLE  = 2'd1,
        PG_COUNT = 2'd2
    } pgen_state_t;

    localparam logic [3:0] ALIAS_CODE1 = 4'd8;
    localparam logic [3:0] ALIAS_CODE2 = 4'd9;

    function automatic logic [3:0] eff_exp(input logic [3:0] code);
        logic [3:0] e;
        unique case (code)
            4'd1:    e = ALIAS_CODE1;
            4'd2:    e = ALIAS_CODE2;
            default: e = code;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/rtc_rate_gen.sv
module rtc_rate_gen
    import rtc_evt_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       div_reset,
    input  logic [3:0] rate_sel,
    input  logic       sqw_en,
    output logic       fire,
    output logic       sqw
);
    pgen_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [3:0]       rate_q;
    logic [3:0]       e;
    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W-1:0] cnt_shift;
    logic             half_hi;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PG_HOLD: begin
                if (!div_reset)
                    state_d = (rate_sel == 4'd0) ? PG_IDLE : PG_COUNT;
            end
            PG_IDLE: begin
                if (div_reset)              state_d = PG_HOLD;
                else if (rate_sel != 4'd0)  state_d = PG_COUNT;
            end
            PG_COUNT: begin
                if (div_reset)              state_d = PG_HOLD;
                else if (rate_sel == 4'd0)  state_d = PG_IDLE;
            end
            default: state_d = PG_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PG_HOLD;
        else        state_q <= state_d;
    end

    // period decode
    always_comb begin
        e         = eff_exp(rate_sel);
        last_cnt  = (CNT_W'(1) << (e - 4'd1)) - CNT_W'(1);
        cnt_shift = cnt_q >> (e - 4'd2);
        half_hi   = (e >= 4'd3) && cnt_shift[0];
    end

    // outputs: counter, event pulse, square wave
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rate_q <= '0;
            fire   <= 1'b0;
            sqw    <= 1'b0;
        end else begin
            rate_q <= rate_sel;
            fire   <= 1'b0;
            if (state_q != PG_COUNT || rate_sel != rate_q) begin
                cnt_q <= '0;
            end else if (tick) begin
                if (cnt_q == last_cnt) begin
                    cnt_q <= '0;
                    fire  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
            sqw <= sqw_en && (state_q == PG_COUNT) && half_hi;
        end
    end

endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       per_ev,
    input  logic       alm_ev,
    input  logic       upd_ev,
    input  logic       clr,
    input  logic       per_en,
    input  logic       alm_en,
    input  logic       upd_en,
    output logic [2:0] flags,
    output logic       req
);
    // flags = {periodic, alarm, update}
    logic [2:0] ev;

    always_comb ev = {per_ev, alm_ev, upd_ev};

    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= ev | (flags & {3{~clr}});
    end

    always_comb req = |(flags & {per_en, alm_en, upd_en});

endmodule

// File: rtl/rtc_reg_port.sv
module rtc_reg_port #(
    parameter logic [7:0] IDX_A   = 8'h0A,
    parameter logic [7:0] IDX_B   = 8'h0B,
    parameter logic [7:0] IDX_C   = 8'h0C,
    parameter logic [7:0] IDX_D   = 8'h0D,
    parameter logic [6:0] A_RST   = 7'h20,
    parameter logic [7:0] D_VALUE = 8'h80
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_sel,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    input  logic       update_busy,
    input  logic [7:0] c_byte,
    output logic [7:0] rdata,
    output logic [7:0] idx_q,
    output logic [2:0] div_sel,
    output logic [3:0] rate_sel,
    output logic       b_halt,
    output logic       b_per_en,
    output logic       b_alm_en,
    output logic       b_upd_en,
    output logic       b_sqw_en,
    output logic       c_read
);
    logic [6:0] reg_a;
    logic [7:0] reg_b;
    logic [7:0] rd_mux;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            reg_a <= A_RST;
            reg_b <= '0;
        end else if (wr_en) begin
            if (!acc_sel)            idx_q <= wdata;
            else if (idx_q == IDX_A) reg_a <= wdata[6:0];
            else if (idx_q == IDX_B) reg_b <= wdata;
        end
    end

    always_comb begin
        if      (idx_q == IDX_A) rd_mux = {update_busy, reg_a};
        else if (idx_q == IDX_B) rd_mux = reg_b;
        else if (idx_q == IDX_C) rd_mux = c_byte;
        else if (idx_q == IDX_D) rd_mux = D_VALUE;
        else                     rd_mux = 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 rdata <= '0;
        else if (rd_en && acc_sel)  rdata <= rd_mux;
    end

    always_comb begin
        c_read   = rd_en && acc_sel && (idx_q == IDX_C);
        div_sel  = reg_a[6:4];
        rate_sel = reg_a[3:0];
        b_halt   = reg_b[7];
        b_per_en = reg_b[6];
        b_alm_en = reg_b[5];
        b_upd_en = reg_b[4];
        b_sqw_en = reg_b[3];
    end

endmodule

// File: rtl/rtc_event_ctrl.sv
module rtc_event_ctrl #(
    parameter int         MAX_EXP = 15,
    parameter logic [7:0] IDX_A   = 8'h0A,
    parameter logic [7:0] IDX_B   = 8'h0B,
    parameter logic [7:0] IDX_C   = 8'h0C,
    parameter logic [7:0] IDX_D   = 8'h0D
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_32k,
    input  logic       acc_sel,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       update_busy,
    input  logic       alarm_match,
    input  logic       update_done,
    output logic       irq,
    output logic       sqw_out,
    output logic       tod_run
);
    localparam int         CNT_W   = MAX_EXP;
    localparam logic [2:0] DIV_RUN = 3'b010;

    logic [7:0] idx_q;
    logic [2:0] div_sel;
    logic [3:0] rate_sel;
    logic       b_halt, b_per_en, b_alm_en, b_upd_en, b_sqw_en;
    logic       c_read;
    logic       pg_fire;
    logic       div_reset;
    logic [2:0] flag_vec;
    logic       req;
    logic [7:0] c_byte;

    always_comb begin
        div_reset = (div_sel[2:1] == 2'b11);
        c_byte    = {req, flag_vec, 4'b0000};
        tod_run   = (div_sel == DIV_RUN) && !b_halt;
        irq       = req;
    end

    rtc_reg_port #(
        .IDX_A(IDX_A), .IDX_B(IDX_B), .IDX_C(IDX_C), .IDX_D(IDX_D),
        .A_RST(7'h20), .D_VALUE(8'h80)
    ) u_port (
        .clk(clk), .rst_n(rst_n), .acc_sel(acc_sel), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .update_busy(update_busy),
        .c_byte(c_byte), .rdata(rdata), .idx_q(idx_q), .div_sel(div_sel),
        .rate_sel(rate_sel), .b_halt(b_halt), .b_per_en(b_per_en),
        .b_alm_en(b_alm_en), .b_upd_en(b_upd_en), .b_sqw_en(b_sqw_en),
        .c_read(c_read)
    );

    rtc_rate_gen #(.CNT_W(CNT_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .tick(tick_32k), .div_reset(div_reset),
        .rate_sel(rate_sel), .sqw_en(b_sqw_en), .fire(pg_fire), .sqw(sqw_out)
    );

    rtc_flag_unit u_flags (
        .clk(clk), .rst_n(rst_n), .per_ev(pg_fire), .alm_ev(alarm_match),
        .upd_ev(update_done), .clr(c_read), .per_en(b_per_en),
        .alm_en(b_alm_en), .upd_en(b_upd_en), .flags(flag_vec), .req(req)
    );

endmodule

// File: rtl/rtc_event_ctrl_chk.sv
module rtc_event_ctrl_chk #(
    parameter logic [7:0] IDX_A = 8'h0A,
    parameter logic [7:0] IDX_D = 8'h0D
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_32k,
    input logic       acc_sel,
    input logic       rd_en,
    input logic [7:0] rdata,
    input logic       update_busy,
    input logic       alarm_match,
    input logic       update_done,
    input logic [7:0] idx_q,
    input logic       pg_fire,
    input logic       div_reset,
    input logic [2:0] flag_vec,
    input logic       c_read,
    input logic       b_sqw_en,
    input logic       sqw_out
);
    // R3: periodic events only follow a time-base tick
    p_fire_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pg_fire |-> $past(tick_32k));

    // R5: generator quiet while divider held in reset
    p_hold_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (div_reset && $past(div_reset)) |=> !pg_fire);

    // R2: busy bit mirrors the input at read time
    p_busy_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && acc_sel && idx_q == IDX_A) |=> rdata[7] == $past(update_busy));

    // R11: power-status register is constant
    p_d_const_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && acc_sel && idx_q == IDX_D) |=> rdata == 8'h80);

    // R9: read of flag register clears all flags when no event coincides
    p_c_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (c_read && !alarm_match && !update_done && !pg_fire) |=> flag_vec == 3'b000);

    // R7: alarm flag is sticky until read
    p_alarm_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_vec[1] && !c_read) |=> flag_vec[1]);

    // R10: coinciding update event survives the clearing read
    p_same_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (c_read && update_done) |=> flag_vec[0]);

    // R12: no square wave while disabled
    p_sqw_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !b_sqw_en |=> !sqw_out);

endmodule

bind rtc_event_ctrl rtc_event_ctrl_chk #(.IDX_A(IDX_A), .IDX_D(IDX_D)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .acc_sel(acc_sel),
    .rd_en(rd_en), .rdata(rdata), .update_busy(update_busy),
    .alarm_match(alarm_match), .update_done(update_done), .idx_q(idx_q),
    .pg_fire(pg_fire), .div_reset(div_reset), .flag_vec(flag_vec),
    .c_read(c_read), .b_sqw_en(b_sqw_en), .sqw_out(sqw_out)
);

// File: tb/rtc_event_ctrl_test.sv
`timescale 1ns/1ps
module rtc_event_ctrl_test;
    localparam int TICK_DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic       acc_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       update_busy = 1'b0;
    logic       alarm_match = 1'b0;
    logic       update_done = 1'b0;
    logic       irq, sqw_out, tod_run;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int tdiv = 0;

    rtc_event_ctrl uut (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .acc_sel(acc_sel),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .update_busy(update_busy), .alarm_match(alarm_match),
        .update_done(update_done), .irq(irq), .sqw_out(sqw_out),
        .tod_run(tod_run)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        tdiv     <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        tick_32k <= (tdiv == TICK_DIV - 1);
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic set_index(input logic [7:0] idx);
        @(negedge clk); acc_sel = 1'b0; wr_en = 1'b1; wdata = idx;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic write_reg(input logic [7:0] idx, input logic [7:0] val);
        set_index(idx);
        acc_sel = 1'b1; wr_en = 1'b1; wdata = val;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [7:0] idx, output logic [7:0] val);
        set_index(idx);
        acc_sel = 1'b1; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        val = rdata;
    endtask

    task automatic wait_irq(input int limit, output int when);
        when = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (irq) begin when = cyc; break; end
        end
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) alarm_match = 1'b1; else update_done = 1'b1;
        @(negedge clk);
        alarm_match = 1'b0; update_done = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R13 irq", irq, 0);
        read_reg(8'h0A, v); chk("R13 A", v, 8'h20);
        read_reg(8'h0B, v); chk("R13 B", v, 8'h00);
        read_reg(8'h0C, v); chk("R13 C", v, 8'h00);
    endtask

    task automatic t_access;
        logic [7:0] v;
        write_reg(8'h0B, 8'h07); read_reg(8'h0B, v); chk("R1 B readback", v, 8'h07);
        read_reg(8'h05, v); chk("R1 undecoded", v, 8'h00);
        write_reg(8'h0B, 8'h00);
        update_busy = 1'b1;
        read_reg(8'h0A, v); chk("R2 busy set", v, 8'hA0);
        update_busy = 1'b0;
        write_reg(8'h0A, 8'hA0); read_reg(8'h0A, v); chk("R2 write ignored", v, 8'h20);
        write_reg(8'h0C, 8'hFF); read_reg(8'h0C, v); chk("R11 C write", v, 8'h00);
        write_reg(8'h0D, 8'h00); read_reg(8'h0D, v); chk("R11 D", v, 8'h80);
    endtask

    task automatic t_tod_run;
        chk("R6 run", tod_run, 1);
        write_reg(8'h0B, 8'h80); chk("R6 halt", tod_run, 0);
        write_reg(8'h0B, 8'h00);
        write_reg(8'h0A, 8'h60); chk("R6 div110", tod_run, 0);
        write_reg(8'h0A, 8'h30); chk("R6 div011", tod_run, 0);
        write_reg(8'h0A, 8'h20); chk("R6 div010", tod_run, 1);
    endtask

    task automatic t_period(input int code);
        int eff, expv, t0, t1;
        logic [7:0] v;
        eff  = (code == 1) ? 8 : (code == 2) ? 9 : code;
        expv = (1 << (eff - 1)) * TICK_DIV;
        write_reg(8'h0A, 8'h20 | code[7:0]);
        write_reg(8'h0B, 8'h40);
        read_reg(8'h0C, v);
        wait_irq(3 * expv + 50, t0);
        read_reg(8'h0C, v);
        wait_irq(3 * expv + 50, t1);
        read_reg(8'h0C, v);
        chk($sformatf("R3 interval code %0d", code), t1 - t0, expv);
        write_reg(8'h0B, 8'h00);
        write_reg(8'h0A, 8'h20);
    endtask

    task automatic t_off_hold;
        logic [7:0] v;
        read_reg(8'h0C, v);
        repeat (3000) @(negedge clk);
        read_reg(8'h0C, v); chk("R4 code0 no flag", v, 8'h00);
        write_reg(8'h0A, 8'h63);
        read_reg(8'h0C, v);
        repeat (200) @(negedge clk);
        read_reg(8'h0C, v); chk("R5 hold no flag", v, 8'h00);
        write_reg(8'h0A, 8'h23);
        repeat (100) @(negedge clk);
        read_reg(8'h0C, v); chk("R5 release flag", v & 8'h40, 8'h40);
        write_reg(8'h0A, 8'h20);
    endtask

    task automatic t_flags;
        logic [7:0] v;
        write_reg(8'h0A, 8'h23);
        repeat (50) @(negedge clk);
        chk("R8 irq off no enable", irq, 0);
        read_reg(8'h0C, v); chk("R7 periodic flag", v, 8'h40);
        write_reg(8'h0A, 8'h20);
        write_reg(8'h0B, 8'h40);
        repeat (30) @(negedge clk);
        chk("R8 irq on", irq, 0);
        write_reg(8'h0A, 8'h23);
        repeat (30) @(negedge clk);
        chk("R8 irq enabled", irq, 1);
        write_reg(8'h0A, 8'h20);
        read_reg(8'h0C, v); chk("R8 C bit7", v, 8'hC0);
        chk("R9 irq cleared", irq, 0);
        write_reg(8'h0B, 8'h20);
        pulse(0);
        chk("R9 alarm irq", irq, 1);
        read_reg(8'h0C, v); chk("R9 alarm read", v, 8'hA0);
        chk("R9 irq low after read", irq, 0);
        read_reg(8'h0C, v); chk("R9 cleared", v, 8'h00);
        write_reg(8'h0B, 8'h00);
        pulse(1);
        read_reg(8'h0C, v); chk("R7 update flag", v, 8'h10);
    endtask

    task automatic t_same_cycle;
        logic [7:0] v;
        set_index(8'h0C);
        acc_sel = 1'b1; rd_en = 1'b1; update_done = 1'b1;
        @(negedge clk); rd_en = 1'b0; update_done = 1'b0;
        chk("R10 not in returned byte", rdata, 8'h00);
        read_reg(8'h0C, v); chk("R10 flag survives", v, 8'h10);
    endtask

    task automatic t_sqw;
        int hi;
        write_reg(8'h0A, 8'h23);
        write_reg(8'h0B, 8'h08);
        repeat (40) @(negedge clk);
        hi = 0;
        for (int i = 0; i < 64; i++) begin @(negedge clk); if (sqw_out) hi++; end
        chk("R12 duty", hi, 32);
        write_reg(8'h0B, 8'h00);
        repeat (4) @(negedge clk);
        hi = 0;
        for (int i = 0; i < 64; i++) begin @(negedge clk); if (sqw_out) hi++; end
        chk("R12 disabled", hi, 0);
        write_reg(8'h0A, 8'h20);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_access();
        t_tod_run();
        t_off_hold();
        t_flags();
        t_same_cycle();
        t_period(3);
        t_period(4);
        t_period(6);
        t_period(1);
        t_period(2);
        t_sqw();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule